// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Target Cache and Return Stack

This block sits in the instruction fetch stage and, in the same cycle as the instruction cache access, turns the current fetch address into a predicted next fetch address. A direct-mapped, tagged target cache is indexed by the fetch address. On a hit it supplies either a stored branch target or, for entries flagged as returns, the top of a circular return address stack. On a miss the fetch continues sequentially at PC+4.

The decode stage reports each decoded control instruction back to the block. A call pushes its own address plus 4 onto the return stack, and a return pops it. When a taken branch's computed target differs from the target that fetch predicted, the block raises a one-cycle redirect that carries the computed address, which costs the pipeline one bubble. In the same cycle it installs or overwrites the target cache entry for that branch. Direction prediction, multi-instruction fetch and repair of the return stack after wrong-path execution are outside this block.

Top module: `target_predictor`

## Requirements
- R1: After reset every target cache entry is invalid, so every fetch address misses, and `redirect_valid` is 0.
- R2: On a miss, `pred_hit` is 0, `pred_from_stack` is 0 and `pred_pc` equals `fetch_pc + 4` in the same cycle.
- R3: On a hit to an entry not flagged as a return, `pred_hit` is 1, `pred_from_stack` is 0 and `pred_pc` is the stored target, combinationally in the same cycle.
- R4: The entry index is `fetch_pc[IDX_W+1:2]` and the tag is `fetch_pc[PC_W-1:IDX_W+2]`. The low two bits are ignored. An address that shares an index with a stored entry but has a different tag misses.
- R5: A mismatch is a cycle with `dec_valid`, `dec_taken` and `dec_target != dec_pred_target`. For each mismatch, `redirect_valid` is 1 in the following cycle only, with `redirect_pc = dec_target`. Without a mismatch, `redirect_valid` is 0.
- R6: A mismatch writes the entry for `dec_pc` with valid=1, its tag, target `dec_target` and return flag `dec_return`. The write replaces any earlier occupant of that index, and fetch sees it from the next cycle.
- R7: `dec_valid && dec_call` pushes `dec_pc + 4` onto the return stack. If `dec_call` and `dec_return` are both set, only the push happens.
- R8: On a hit to an entry flagged as a return, `pred_hit` and `pred_from_stack` are 1 and `pred_pc` is the current top of the return stack.
- R9: `dec_valid && dec_return` without `dec_call` pops the stack, so the top becomes the entry pushed before it.
- R10: The stack is circular with `RAS_DEPTH` slots. Pushing beyond the depth overwrites the oldest slot, and the occupancy count saturates at the depth, so only the newest `RAS_DEPTH` return addresses are recovered in reverse order.
- R11: A pop when the occupancy count is zero changes neither the stack pointer nor the value at the top of the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Current fetch address |
| pred_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | Target cache hit for fetch_pc |
| pred_from_stack | output | 1 | Prediction taken from the return stack top |
| dec_valid | input | 1 | Decode reports a control instruction |
| dec_pc | input | PC_W | Address of the decoded instruction |
| dec_taken | input | 1 | Decoded branch is taken |
| dec_target | input | PC_W | Target computed at decode |
| dec_pred_target | input | PC_W | Target predicted at fetch for this instruction |
| dec_call | input | 1 | Decoded instruction is a call |
| dec_return | input | 1 | Decoded instruction is a return |
| redirect_valid | output | 1 | One-cycle fetch redirect request |
| redirect_pc | output | PC_W | Corrected fetch address |

## Verification
The bench overflows the return stack by two calls and then unwinds it. A design that grew the count past the depth, or that did not wrap, would hand back stale or reordered return addresses. It keeps popping after the stack is empty, where a pointer that moved would change the predicted return target. It also aliases two addresses onto one index, which catches a tag compare that is too narrow, and it sends a simultaneous call and return, where a design that popped as well would leave the wrong top. Mismatch, match and not-taken reports check that a redirect appears only after a real disagreement and lasts one cycle.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

    localparam int unsigned PC_W = 32;

    typedef logic [PC_W-1:0] pc_t;

    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_CACHE = 2'd1,
        SRC_STACK = 2'd2
    } pred_src_e;

    typedef struct packed {
        logic valid;
        pc_t  pc;
        logic taken;
        pc_t  target;
        pc_t  pred_target;
        logic call;
        logic ret;
    } dec_info_t;

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(4);
    endfunction

endpackage

// File: rtl/ftp_target_cache.sv
module ftp_target_cache
    import ftp_pkg::*;
#(
    parameter int unsigned ENTRIES = 16
) (
    input  logic clk,
    input  logic rst,
    input  pc_t  lk_pc,
    output logic lk_hit,
    output pc_t  lk_target,
    output logic lk_ret,
    input  logic wr_en,
    input  pc_t  wr_pc,
    input  pc_t  wr_target,
    input  logic wr_ret
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned TAG_W = PC_W - 2 - IDX_W;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    pc_t                tgt_q [ENTRIES];
    logic               ret_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    assign lk_idx = lk_pc[IDX_W+1:2];
    assign lk_tag = lk_pc[PC_W-1:IDX_W+2];
    assign wr_idx = wr_pc[IDX_W+1:2];
    assign wr_tag = wr_pc[PC_W-1:IDX_W+2];

    assign lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_target = tgt_q[lk_idx];
    assign lk_ret    = ret_q[lk_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                tag_q[i] <= '0;
                tgt_q[i] <= '0;
                ret_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
            ret_q[wr_idx] <= wr_ret;
        end
    end

    // R6: an installed entry is valid and tagged with the written address
    a_r6_install_visible: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/ftp_return_stack.sv
module ftp_return_stack
    import ftp_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  pc_t  push_val,
    input  logic pop,
    output pc_t  top
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    pc_t              slot_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] ptr_up, ptr_dn;

    assign ptr_up = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
    assign ptr_dn = (ptr_q == '0) ? PTR_LAST : ptr_q - PTR_W'(1);
    assign top    = slot_q[ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            cnt_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                slot_q[i] <= '0;
            end
        end else if (push) begin
            slot_q[ptr_up] <= push_val;
            ptr_q          <= ptr_up;
            if (cnt_q != CNT_FULL) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (pop && (cnt_q != '0)) begin
            ptr_q <= ptr_dn;
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R7: a push leaves the pushed value on top
    a_r7_push_on_top: assert property (@(posedge clk) disable iff (rst)
        push |=> top == $past(push_val));

    // R10: occupancy saturates when pushing onto a full stack
    a_r10_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (push && cnt_q == CNT_FULL) |=> cnt_q == CNT_FULL);

    // R11: popping an empty stack disturbs nothing
    a_r11_empty_pop_holds: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && cnt_q == '0) |=> $stable(ptr_q) && $stable(top));

endmodule

// File: rtl/ftp_redirect.sv
module ftp_redirect
    import ftp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dec_info_t dec,
    output logic      mismatch,
    output logic      redirect_valid,
    output pc_t       redirect_pc
);
    assign mismatch = dec.valid && dec.taken && (dec.target != dec.pred_target);

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= mismatch;
            if (mismatch) begin
                redirect_pc <= dec.target;
            end
        end
    end

endmodule

// File: rtl/target_predictor.sv
module target_predictor
    import ftp_pkg::*;
#(
    parameter int unsigned BTB_ENTRIES = 16,
    parameter int unsigned RAS_DEPTH   = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic [PC_W-1:0] pred_pc,
    output logic            pred_hit,
    output logic            pred_from_stack,
    input  logic            dec_valid,
    input  logic [PC_W-1:0] dec_pc,
    input  logic            dec_taken,
    input  logic [PC_W-1:0] dec_target,
    input  logic [PC_W-1:0] dec_pred_target,
    input  logic            dec_call,
    input  logic            dec_return,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc
);
    dec_info_t dec;
    logic      mismatch;
    logic      lk_hit, lk_ret;
    pc_t       lk_target, stack_top;
    pred_src_e src;
    logic      do_push, do_pop;

    assign dec = '{valid: dec_valid, pc: dec_pc, taken: dec_taken, target: dec_target,
                   pred_target: dec_pred_target, call: dec_call, ret: dec_return};

    assign do_push = dec.valid && dec.call;
    assign do_pop  = dec.valid && dec.ret && !dec.call;

    ftp_target_cache #(.ENTRIES(BTB_ENTRIES)) u_cache (
        .clk       (clk),
        .rst       (rst),
        .lk_pc     (fetch_pc),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .lk_ret    (lk_ret),
        .wr_en     (mismatch),
        .wr_pc     (dec.pc),
        .wr_target (dec.target),
        .wr_ret    (dec.ret)
    );

    ftp_return_stack #(.DEPTH(RAS_DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (do_push),
        .push_val (seq_pc(dec.pc)),
        .pop      (do_pop),
        .top      (stack_top)
    );

    ftp_redirect u_redir (
        .clk            (clk),
        .rst            (rst),
        .dec            (dec),
        .mismatch       (mismatch),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    always_comb begin
        if (!lk_hit)     src = SRC_SEQ;
        else if (lk_ret) src = SRC_STACK;
        else             src = SRC_CACHE;
    end

    always_comb begin
        unique case (src)
            SRC_CACHE: pred_pc = lk_target;
            SRC_STACK: pred_pc = stack_top;
            default:   pred_pc = seq_pc(fetch_pc);
        endcase
    end

    assign pred_hit        = (src != SRC_SEQ);
    assign pred_from_stack = (src == SRC_STACK);

    // R2: a miss predicts the sequential address
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (rst)
        !pred_hit |-> (pred_pc == fetch_pc + PC_W'(4)) && !pred_from_stack);

    // R5: a redirect only follows a taken, mispredicted decode report
    a_r5_redirect_cause: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> $past(dec_valid && dec_taken) && (redirect_pc != $past(dec_pred_target)));

endmodule

// File: tb/target_predictor_tb.sv
module target_predictor_tb_top;
    localparam int NE = 16;
    localparam int ND = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0, dec_pc = '0, dec_target = '0, dec_pred_target = '0;
    logic        dec_valid = 1'b0, dec_taken = 1'b0, dec_call = 1'b0, dec_return = 1'b0;
    logic [31:0] pred_pc, redirect_pc;
    logic        pred_hit, pred_from_stack, redirect_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    target_predictor #(.BTB_ENTRIES(NE), .RAS_DEPTH(ND)) dut_i (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_pc(pred_pc), .pred_hit(pred_hit),
        .pred_from_stack(pred_from_stack), .dec_valid(dec_valid), .dec_pc(dec_pc),
        .dec_taken(dec_taken), .dec_target(dec_target), .dec_pred_target(dec_pred_target),
        .dec_call(dec_call), .dec_return(dec_return), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    // reference model
    bit          m_vld [NE];
    logic [25:0] m_tag [NE];
    logic [31:0] m_tgt [NE];
    bit          m_ret [NE];
    logic [31:0] m_slot [ND];
    int          m_ptr = 0;
    int          m_cnt = 0;

    function automatic bit m_hit(input logic [31:0] pc);
        return m_vld[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
    endfunction

    function automatic bit m_fromstk(input logic [31:0] pc);
        return m_hit(pc) && m_ret[pc[5:2]];
    endfunction

    function automatic logic [31:0] m_next(input logic [31:0] pc);
        if (!m_hit(pc)) return pc + 32'd4;
        if (m_ret[pc[5:2]]) return m_slot[m_ptr];
        return m_tgt[pc[5:2]];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input string rq_f, input logic [31:0] fpc,
                         input logic dv, input logic [31:0] dpc, input logic tk,
                         input logic [31:0] tgt, input logic [31:0] ptgt,
                         input logic cl, input logic rt, input string rq_d);
        bit          exp_rv;
        logic [31:0] exp_rp;
        @(negedge clk);
        fetch_pc = fpc; dec_valid = dv; dec_pc = dpc; dec_taken = tk;
        dec_target = tgt; dec_pred_target = ptgt; dec_call = cl; dec_return = rt;
        #1;
        chk(rq_f, "pred_pc", pred_pc, m_next(fpc));
        chk(rq_f, "pred_hit", {31'd0, pred_hit}, {31'd0, m_hit(fpc)});
        chk(rq_f, "pred_from_stack", {31'd0, pred_from_stack}, {31'd0, m_fromstk(fpc)});
        exp_rv = dv && tk && (tgt != ptgt);
        exp_rp = tgt;
        @(posedge clk);
        // model update with pre-edge values
        if (exp_rv) begin
            m_vld[dpc[5:2]] = 1'b1; m_tag[dpc[5:2]] = dpc[31:6];
            m_tgt[dpc[5:2]] = tgt;  m_ret[dpc[5:2]] = rt;
        end
        if (dv && cl) begin
            m_ptr = (m_ptr + 1) % ND;
            m_slot[m_ptr] = dpc + 32'd4;
            if (m_cnt < ND) m_cnt++;
        end else if (dv && rt && m_cnt > 0) begin
            m_ptr = (m_ptr + ND - 1) % ND;
            m_cnt--;
        end
        #1;
        chk(rq_d, "redirect_valid", {31'd0, redirect_valid}, {31'd0, exp_rv});
        if (exp_rv) chk(rq_d, "redirect_pc", redirect_pc, exp_rp);
    endtask

    task automatic idle_fetch(input string rq, input logic [31:0] fpc);
        cycle(rq, fpc, 1'b0, 32'd0, 1'b0, 32'd0, 32'd0, 1'b0, 1'b0, "R5");
    endtask

    localparam logic [31:0] PA   = 32'h0000_4010; // index 4
    localparam logic [31:0] PA2  = 32'h0000_8010; // same index, other tag
    localparam logic [31:0] RETP = 32'h0000_1000; // index 0

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_vld[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_ret[i] = 0;
        end
        for (int i = 0; i < ND; i++) m_slot[i] = '0;
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "redirect_valid", {31'd0, redirect_valid}, 32'd0);
        for (int k = 0; k < 4; k++) idle_fetch("R1", 32'h100 * k + 32'h4);
        // R2: plain miss with low bits set
        idle_fetch("R2", 32'h0000_2223);
        // R5/R6: mismatch installs and redirects
        cycle("R2", PA, 1'b1, PA, 1'b1, 32'h0000_9000, PA + 32'd4, 1'b0, 1'b0, "R5");
        idle_fetch("R3", PA);
        idle_fetch("R6", PA);
        // R4: same index, different tag misses
        idle_fetch("R4", PA2);
        // R5: matching prediction and not-taken give no redirect
        cycle("R3", PA, 1'b1, PA, 1'b1, 32'h0000_9000, 32'h0000_9000, 1'b0, 1'b0, "R5");
        cycle("R3", PA, 1'b1, PA, 1'b0, 32'h0000_7000, 32'h0000_9000, 1'b0, 1'b0, "R5");
        // R6: alias overwrites the entry
        cycle("R4", PA2, 1'b1, PA2, 1'b1, 32'h0000_A000, 32'd0, 1'b0, 1'b0, "R6");
        idle_fetch("R6", PA2);
        idle_fetch("R4", PA);
        // back-to-back mismatches give back-to-back single pulses
        cycle("R3", PA2, 1'b1, PA, 1'b1, 32'h0000_B000, 32'd0, 1'b0, 1'b0, "R5");
        cycle("R3", PA, 1'b1, PA, 1'b1, 32'h0000_C000, 32'd0, 1'b0, 1'b0, "R5");
        idle_fetch("R5", PA);
        // R8/R11: return entry installed while stack empty (pop on empty)
        cycle("R2", RETP, 1'b1, RETP, 1'b1, 32'hDEAD_0000, 32'd0, 1'b0, 1'b1, "R11");
        idle_fetch("R8", RETP);
        idle_fetch("R11", RETP);
        // R7/R10: push ND+2 calls, watching the top
        for (int k = 0; k < ND + 2; k++)
            cycle("R7", RETP, 1'b1, 32'h0000_2000 + 32'h10 * k, 1'b0, 32'd0, 32'd0, 1'b1, 1'b0, "R5");
        idle_fetch("R10", RETP);
        // R9/R10: unwind the stack
        for (int k = 0; k < ND; k++)
            cycle("R9", RETP, 1'b1, 32'h0000_3000, 1'b0, 32'd0, 32'd0, 1'b0, 1'b1, "R10");
        // R11: pops on an empty stack
        for (int k = 0; k < 2; k++)
            cycle("R11", RETP, 1'b1, 32'h0000_3000, 1'b0, 32'd0, 32'd0, 1'b0, 1'b1, "R11");
        idle_fetch("R11", RETP);
        // R7: call and return together only push
        cycle("R8", RETP, 1'b1, 32'h0000_5550, 1'b0, 32'd0, 32'd0, 1'b1, 1'b0, "R7");
        cycle("R8", RETP, 1'b1, 32'h0000_6660, 1'b0, 32'd0, 32'd0, 1'b1, 1'b1, "R7");
        idle_fetch("R7", RETP);
        cycle("R9", RETP, 1'b1, 32'h0000_3000, 1'b0, 32'd0, 32'd0, 1'b0, 1'b1, "R9");
        idle_fetch("R9", RETP);
        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [31:0] fpc, dpc, tgt, ptgt;
            logic dv, tk, cl, rt;
            fpc  = {24'd0, 2'($urandom_range(0, 3)), 4'($urandom), 2'b00} + 32'h1000;
            dpc  = {24'd0, 2'($urandom_range(0, 3)), 4'($urandom), 2'b00} + 32'h1000;
            dv   = ($urandom_range(0, 9) < 7);
            tk   = ($urandom_range(0, 9) < 6);
            cl   = ($urandom_range(0, 9) < 2);
            rt   = ($urandom_range(0, 9) < 2);
            tgt  = {$urandom} & 32'hFFFF_FFFC;
            ptgt = ($urandom_range(0, 1) == 1) ? tgt : m_next(dpc);
            cycle(m_fromstk(fpc) ? "R8" : (m_hit(fpc) ? "R3" : "R2"),
                  fpc, dv, dpc, tk, tgt, ptgt, cl, rt, "R5");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule